// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers five interrupt sources for a small 4-bit controller core: two external request pins, overflow pulses from two timers and a completion pulse from a serial port. Each source owns a pending flag that only hardware can set and a mask bit. A single global enable gates all five sources. When the enable is on and at least one source is both pending and unmasked, the block selects the most urgent such source. It raises a one-cycle take strobe together with the 16-bit entry address of that source's handler. In the same cycle it drops the global enable, so the handler cannot be entered again before software allows it.

The control bits are reached through a nibble-wide register window of four addresses. Reads return a whole nibble selected by a read address. Writes change one bit, chosen by an address and a bit index. The core uses these bits to unmask sources, acknowledge requests and turn the enable back on. The take strobe and vector are plain outputs with no back-pressure. The core must act on the strobe in the cycle it is high, because the enable has already been cleared and the strobe does not repeat.

Top module: `pri_irq_ctrl`

## Requirements
- R1: After reset the global enable and all five pending flags are 0 and all five mask bits are 1, so the window reads 4'h4, 4'h5, 4'h5 and 4'h0 at addresses 0 to 3.
- R2: Window layout, bit 0 first: address 0 holds enable, pending INT0, mask INT0, pending INT1. Address 1 holds mask INT1, pending timer A, mask timer A, pending timer B. Address 2 holds mask timer B, pending serial, mask serial and a spare bit. Address 3 is reserved. The spare bit and address 3 always read 0.
- R3: A bit write with value 1 to a pending flag has no effect, and a write with value 0 clears it. Writes to mask bits and the enable store the written value. Writes to the spare bit or to address 3 have no effect.
- R4: If a source event arrives in the same cycle as a software clear of that source's pending flag, the flag ends up 1.
- R5: A source requests only when its pending flag is 1 and its mask is 0. The take strobe is high exactly when the enable is 1 and at least one source requests.
- R6: Priority, highest first: INT0, INT1, timer A, timer B, serial. A source is chosen only when no source above it requests.
- R7: The vector during take is 16'h0002 (INT0), 16'h0004 (INT1), 16'h0006 (timer A), 16'h0008 (timer B) or 16'h000C (serial).
- R8: Take lasts one cycle. The enable reads 0 from the next cycle on, and the chosen source's pending flag stays 1 until software clears it. If take and a software write to the enable fall in the same cycle, the clear wins.
- R9: Each external pin passes through a two-flop synchronizer, and a rising edge of the synchronized signal sets the pending flag. A pin that rises before clock edge n shows its flag set after edge n+2. A pin held high does not set the flag again after it has been cleared.
- R10: A timer or serial event is a single-cycle pulse that sets its pending flag at the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_i | input | 2 | External request pins, bit 0 INT0, bit 1 INT1 (asynchronous) |
| pulse_evt_i | input | 3 | Single-cycle events: bit 0 timer A, bit 1 timer B, bit 2 serial |
| wr_en_i | input | 1 | Bit write strobe |
| wr_addr_i | input | 2 | Nibble address of the bit write |
| wr_bit_i | input | 2 | Bit index inside the nibble |
| wr_val_i | input | 1 | Value written |
| rd_addr_i | input | 2 | Nibble address for reading |
| rd_data_o | output | 4 | Nibble read data (combinational) |
| irq_take_o | output | 1 | One-cycle interrupt take strobe |
| irq_vec_o | output | 16 | Handler entry address, 0 when no take |

## Verification
A flipped or stuck pending flag, mask bit or enable shows up in the read window during the very next cycle. It also shows up as a take strobe that appears when it should not, fails to appear, or lasts more than one cycle. A fault in the priority chain or the vector selection appears at the take cycle itself, as a wrong entry address whenever two or more sources request together. A fault in the synchronizer or edge detector moves the flag's set cycle away from the third edge after the pin rises, or sets the flag again while the pin is held high.

// File: rtl/pri_irq_pkg.sv
package pri_irq_pkg;
  localparam int NSRC    = 5;
  localparam int NEXT    = 2;
  localparam int NPULSE  = NSRC - NEXT;
  localparam int VEC_W   = 16;
  localparam int NIB_W   = 4;
  localparam int NREG    = 4;
  localparam int RA_W    = $clog2(NREG);
  localparam int RB_W    = $clog2(NIB_W);
  localparam int IDX_W   = RA_W + RB_W;
  localparam int VIEW_W  = NREG * NIB_W;

  // slot of each control bit in the flat window: enable at 0,
  // then pending/mask pairs per source in priority order
  function automatic logic [IDX_W-1:0] pend_slot(input int k);
    return IDX_W'(1 + 2 * k);
  endfunction

  function automatic logic [IDX_W-1:0] mask_slot(input int k);
    return IDX_W'(2 + 2 * k);
  endfunction

  function automatic logic [VEC_W-1:0] src_vector(input int k);
    logic [VEC_W-1:0] v;
    case (k)
      0:       v = 16'h0002;
      1:       v = 16'h0004;
      2:       v = 16'h0006;
      3:       v = 16'h0008;
      default: v = 16'h000C;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import pri_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  evt_i,
  input  logic             take_i,
  input  logic             wr_en_i,
  input  logic [RA_W-1:0]  wr_addr_i,
  input  logic [RB_W-1:0]  wr_bit_i,
  input  logic             wr_val_i,
  input  logic [RA_W-1:0]  rd_addr_i,
  output logic [NIB_W-1:0] rd_data_o,
  output logic             ie_o,
  output logic [NSRC-1:0]  pend_o,
  output logic [NSRC-1:0]  mask_o
);
  logic [IDX_W-1:0]  widx;
  logic [VIEW_W-1:0] view;
  logic              ie_q;
  logic [NSRC-1:0]   pend_q;
  logic [NSRC-1:0]   mask_q;

  assign widx = {wr_addr_i, wr_bit_i};

  generate
    for (genvar k = 0; k < NSRC; k++) begin : g_src
      localparam logic [IDX_W-1:0] PSLOT = pend_slot(k);
      localparam logic [IDX_W-1:0] MSLOT = mask_slot(k);

      // hardware event beats a software clear; software never sets
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          pend_q[k] <= 1'b0;
        else if (evt_i[k])
          pend_q[k] <= 1'b1;
        else if (wr_en_i && widx == PSLOT && !wr_val_i)
          pend_q[k] <= 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mask_q[k] <= 1'b1;
        else if (wr_en_i && widx == MSLOT)
          mask_q[k] <= wr_val_i;
      end
    end
  endgenerate

  // acceptance clears the enable ahead of any software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ie_q <= 1'b0;
    else if (take_i)
      ie_q <= 1'b0;
    else if (wr_en_i && widx == '0)
      ie_q <= wr_val_i;
  end

  always_comb begin
    view    = '0;
    view[0] = ie_q;
    for (int k = 0; k < NSRC; k++) begin
      view[1 + 2 * k] = pend_q[k];
      view[2 + 2 * k] = mask_q[k];
    end
  end

  assign rd_data_o = view[rd_addr_i * NIB_W +: NIB_W];
  assign ie_o      = ie_q;
  assign pend_o    = pend_q;
  assign mask_o    = mask_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import pri_irq_pkg::*;
(
  input  logic             ie_i,
  input  logic [NSRC-1:0]  pend_i,
  input  logic [NSRC-1:0]  mask_i,
  output logic [NSRC-1:0]  grant_o,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [NSRC-1:0] req;
  logic            any;

  assign req = pend_i & ~mask_i;

  // index 0 is the most urgent source
  always_comb begin
    grant_o = '0;
    any     = 1'b0;
    for (int k = 0; k < NSRC; k++) begin
      if (req[k] && !any) begin
        grant_o[k] = 1'b1;
        any        = 1'b1;
      end
    end
  end

  assign take_o = ie_i & any;

  always_comb begin
    vec_o = '0;
    if (take_o) begin
      for (int k = 0; k < NSRC; k++) begin
        if (grant_o[k]) vec_o = src_vector(k);
      end
    end
  end
endmodule

// File: rtl/pri_irq_ctrl.sv
module pri_irq_ctrl
  import pri_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NEXT-1:0]   ext_irq_i,
  input  logic [NPULSE-1:0] pulse_evt_i,
  input  logic              wr_en_i,
  input  logic [RA_W-1:0]   wr_addr_i,
  input  logic [RB_W-1:0]   wr_bit_i,
  input  logic              wr_val_i,
  input  logic [RA_W-1:0]   rd_addr_i,
  output logic [NIB_W-1:0]  rd_data_o,
  output logic              irq_take_o,
  output logic [VEC_W-1:0]  irq_vec_o
);
  logic [NEXT-1:0] ext_rise;
  logic [NSRC-1:0] evt;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] mask;
  logic [NSRC-1:0] grant;
  logic            ie;
  logic            take;

  generate
    for (genvar e = 0; e < NEXT; e++) begin : g_ext
      irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_irq_i[e]),
        .rise_o (ext_rise[e])
      );
    end
  endgenerate

  assign evt = {pulse_evt_i, ext_rise};

  irq_flag_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt),
    .take_i    (take),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_bit_i  (wr_bit_i),
    .wr_val_i  (wr_val_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .ie_o      (ie),
    .pend_o    (pend),
    .mask_o    (mask)
  );

  irq_arbiter u_arb (
    .ie_i    (ie),
    .pend_i  (pend),
    .mask_i  (mask),
    .grant_o (grant),
    .take_o  (take),
    .vec_o   (irq_vec_o)
  );

  assign irq_take_o = take;
endmodule

// File: rtl/pri_irq_ctrl_chk.sv
module pri_irq_ctrl_chk
  import pri_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             take,
  input logic [VEC_W-1:0] vec,
  input logic             ie,
  input logic [NSRC-1:0]  pend,
  input logic [NSRC-1:0]  mask,
  input logic [NSRC-1:0]  evt,
  input logic [NSRC-1:0]  grant
);
  // R5
  take_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (ie && ((pend & ~mask) != '0)));

  // R8
  take_drops_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !ie);

  // R8
  take_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);

  // R6
  grant_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R7
  vec_top_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && pend[0] && !mask[0]) |-> vec == 16'h0002);

  // R7
  vec_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (pend[3:0] & ~mask[3:0]) == 4'b0) |-> vec == 16'h000C);

  generate
    for (genvar k = 0; k < NSRC; k++) begin : g_flag
      // R3
      flag_hw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[k]) |-> $past(evt[k]));
      // R4
      flag_evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt[k] |=> pend[k]);
    end
  endgenerate
endmodule

bind pri_irq_ctrl pri_irq_ctrl_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .take  (irq_take_o),
  .vec   (irq_vec_o),
  .ie    (ie),
  .pend  (pend),
  .mask  (mask),
  .evt   (evt),
  .grant (grant)
);

// File: tb/pri_irq_ctrl_test.sv
module pri_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ext_irq = '0;
  logic [2:0]  pulse_evt = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [1:0]  wr_bit = '0;
  logic        wr_val = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [3:0]  rd_data;
  logic        irq_take;
  logic [15:0] irq_vec;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model of the control state
  logic       m_ie;
  logic [4:0] m_pend, m_mask;
  logic [1:0] m_s1, m_s2, m_pv;
  logic [1:0] pins_now;

  pri_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq), .pulse_evt_i(pulse_evt),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_bit_i(wr_bit), .wr_val_i(wr_val),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_take_o(irq_take),
    .irq_vec_o(irq_vec)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_vec(input logic [4:0] req);
    for (int k = 0; k < 5; k++) begin
      if (req[k]) begin
        case (k)
          0: return 16'h0002;
          1: return 16'h0004;
          2: return 16'h0006;
          3: return 16'h0008;
          default: return 16'h000C;
        endcase
      end
    end
    return 16'h0000;
  endfunction

  function automatic logic [3:0] exp_nib(input logic [1:0] a);
    logic [15:0] v;
    v = '0;
    v[0] = m_ie;
    for (int k = 0; k < 5; k++) begin
      v[1 + 2 * k] = m_pend[k];
      v[2 + 2 * k] = m_mask[k];
    end
    return v[a * 4 +: 4];
  endfunction

  task automatic rd_expect(input logic [1:0] a, input logic [3:0] exp, input string tag);
    rd_addr = a;
    #1;
    chk(tag, {12'b0, rd_data}, {12'b0, exp});
  endtask

  task automatic step(input logic [1:0] pins, input logic [2:0] pul, input logic we,
                      input logic [3:0] widx, input logic wv, input logic [1:0] ra);
    logic [4:0]  req, evt;
    logic        tk;
    logic [15:0] ev;
    ext_irq = pins; pulse_evt = pul; wr_en = we;
    {wr_addr, wr_bit} = widx; wr_val = wv; rd_addr = ra;
    pins_now = pins;
    #1;
    req = m_pend & ~m_mask;
    tk  = m_ie && (req != 0);
    ev  = tk ? exp_vec(req) : 16'h0;
    chk("R5 take", {15'b0, irq_take}, {15'b0, tk});
    if (tk) chk("R7 R6 vector", irq_vec, ev);
    chk("R2 read", {12'b0, rd_data}, {12'b0, exp_nib(ra)});
    @(posedge clk);
    evt = {pul, m_s2 & ~m_pv};
    m_pv = m_s2; m_s2 = m_s1; m_s1 = pins;
    for (int k = 0; k < 5; k++) begin
      if (evt[k]) m_pend[k] = 1'b1;
      else if (we && widx == 4'(1 + 2 * k) && !wv) m_pend[k] = 1'b0;
      if (we && widx == 4'(2 + 2 * k)) m_mask[k] = wv;
    end
    if (tk) m_ie = 1'b0;
    else if (we && widx == 4'd0) m_ie = wv;
    @(negedge clk);
    wr_en = 1'b0; pulse_evt = '0;
  endtask

  task automatic wr(input logic [3:0] idx, input logic v);
    step(pins_now, 3'b0, 1'b1, idx, v, 2'd0);
  endtask

  task automatic idle();
    step(pins_now, 3'b0, 1'b0, 4'd0, 1'b0, 2'd0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R5 watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_ie = 0; m_pend = '0; m_mask = '1; m_s1 = '0; m_s2 = '0; m_pv = '0; pins_now = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd_expect(2'd0, 4'h4, "R1 addr0");
    rd_expect(2'd1, 4'h5, "R1 addr1");
    rd_expect(2'd2, 4'h5, "R1 addr2");
    rd_expect(2'd3, 4'h0, "R1 addr3");
    #1; chk("R1 no take", {15'b0, irq_take}, 16'h0);

    // R3 ignored writes
    wr(4'd1, 1'b1);  rd_expect(2'd0, 4'h4, "R3 write one to pending INT0");
    wr(4'd11, 1'b1); rd_expect(2'd2, 4'h5, "R3 spare bit");
    wr(4'd13, 1'b1); rd_expect(2'd3, 4'h0, "R3 reserved address");

    // R10 timer A pulse, R5 enable off, R8 take pulse
    wr(4'd6, 1'b0);
    step(pins_now, 3'b001, 1'b0, 4'd0, 1'b0, 2'd1);
    rd_expect(2'd1, 4'b0011, "R10 timer A flag set");
    #1; chk("R5 no take while disabled", {15'b0, irq_take}, 16'h0);
    wr(4'd0, 1'b1);
    #1; chk("R8 take high", {15'b0, irq_take}, 16'h1);
    chk("R7 timer A vector", irq_vec, 16'h0006);
    idle();
    #1; chk("R8 take one cycle", {15'b0, irq_take}, 16'h0);
    rd_expect(2'd0, 4'b0100, "R8 enable cleared");
    rd_expect(2'd1, 4'b0011, "R8 flag kept");

    // R4 event beats clear
    step(pins_now, 3'b001, 1'b1, 4'd5, 1'b0, 2'd1);
    rd_expect(2'd1, 4'b0011, "R4 event wins");
    wr(4'd5, 1'b0);
    rd_expect(2'd1, 4'b0001, "R4 plain clear");

    // R6 R7 timer B over serial, then serial vector
    wr(4'd8, 1'b0); wr(4'd10, 1'b0);
    step(pins_now, 3'b110, 1'b0, 4'd0, 1'b0, 2'd0);
    wr(4'd0, 1'b1);
    #1; chk("R6 timer B first", irq_vec, 16'h0008);
    wr(4'd7, 1'b0);
    wr(4'd0, 1'b1);
    #1; chk("R7 serial vector", irq_vec, 16'h000C);
    wr(4'd9, 1'b0);

    // R9 synchronizer latency and no retrigger
    wr(4'd2, 1'b0);
    step(2'b01, 3'b0, 1'b0, 4'd0, 1'b0, 2'd0);
    rd_expect(2'd0, 4'b0000, "R9 edge 1");
    idle(); rd_expect(2'd0, 4'b0000, "R9 edge 2");
    idle(); rd_expect(2'd0, 4'b0010, "R9 edge 3 sets flag");
    wr(4'd1, 1'b0);
    idle(); idle(); idle();
    rd_expect(2'd0, 4'b0000, "R9 held pin no retrigger");
    step(2'b00, 3'b0, 1'b0, 4'd0, 1'b0, 2'd0);

    // constrained random traffic checked against the model
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] p;
      logic [2:0] pu;
      logic [3:0] idx;
      logic       v;
      p = pins_now;
      for (int b = 0; b < 2; b++) if (($urandom % 16) == 0) p[b] = ~p[b];
      for (int b = 0; b < 3; b++) pu[b] = (($urandom % 10) == 0);
      idx = 4'($urandom % 16);
      v = (idx == 4'd0) ? (($urandom % 4) != 0) : 1'($urandom);
      step(p, pu, (($urandom % 2) == 0), idx, v, 2'($urandom));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule